// File: doc/BRIEF.md
# Edge/Level Interrupt Request Capture

This block turns a group of interrupt input lines into a register of pending requests. Each line has its own trigger sense, selected by a trigger-mode register that software writes one byte at a time. When a line is edge-sensed, its request is latched on a rising edge and stays pending until the acknowledge logic clears it. When a line is level-sensed, its request simply follows the input.

The priority and command logic reads the request vector. The acknowledge logic clears requests through a per-line clear vector. The inputs are assumed to be synchronous to the block clock already. Edge detection compares each input with its value in the previous cycle. The trigger-mode register holds only the bits allowed by a fixed per-instance writable mask. Bits outside the mask always read as zero.

Top module: `irq_req_capture`

## Requirements
- R1: While reset is asserted and right after it, every request bit reads 0 and the trigger-mode readback is 0, so every line is edge-sensed (mode bit 0 = edge, 1 = level).
- R2: For a level-sensed line, a high input sets the request bit at the next clock edge.
- R3: For a level-sensed line, a low input clears the request bit at the next clock edge.
- R4: For an edge-sensed line, an input that is high in this cycle and was low in the previous cycle sets the request bit at the next clock edge.
- R5: For an edge-sensed line, a pending request is not cleared by a low input, and an input held high does not set the request again once it has been cleared.
- R6: For an edge-sensed line, asserting its acknowledge-clear bit clears a pending request at the next clock edge.
- R7: For a level-sensed line, the acknowledge-clear bit has no effect, and the request still follows the input.
- R8: When a rising edge and the acknowledge-clear arrive in the same cycle on an edge-sensed line, the request bit ends up set.
- R9: A write strobe stores the write data ANDed with WRITABLE_MASK into the trigger-mode register, visible on the readback one cycle later.
- R10: With the write strobe low, changes on the write data leave the trigger-mode readback unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_LINES | Synchronized raw interrupt lines |
| mode_wr | input | 1 | Trigger-mode register write strobe |
| mode_wdata | input | NUM_LINES | Trigger-mode write data (1 = level, 0 = edge) |
| mode_rdata | output | NUM_LINES | Stored trigger-mode value |
| ack_clr | input | NUM_LINES | Per-line acknowledge clear from the acknowledge logic |
| req_out | output | NUM_LINES | Pending request vector |

## Verification
Every result of this block appears exactly one clock edge after its stimulus. A request reacts to the input and acknowledge sampled at that edge, and the mode readback reacts to a write at that edge. The mode that decides the sense of a line is the value stored before that same edge. The bench drives its inputs on the falling edge. A behavioural model updates on the rising edge, and the outputs are compared with it on the following falling edge, half a cycle after the register update. Directed sequences then read each tagged result on the first falling edge after the stimulus. After that, a pseudo-random phase mixes mode writes, toggles and acknowledges.

// File: rtl/irq_cap_pkg.sv
package irq_cap_pkg;

    // Per-line capture state
    typedef struct packed {
        logic prev;   // input level seen in the previous cycle
        logic req;    // pending request
    } line_state_t;

endpackage

// File: rtl/irq_trig_mode.sv
module irq_trig_mode #(
    parameter int                   NUM_LINES     = 8,
    parameter logic [NUM_LINES-1:0] WRITABLE_MASK = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [NUM_LINES-1:0] wdata,
    output logic [NUM_LINES-1:0] mode
);

    logic [NUM_LINES-1:0] mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (wr) begin
            mode_d = wdata & WRITABLE_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign mode = mode_q;

endmodule

// File: rtl/irq_line_cap.sv
module irq_line_cap
    import irq_cap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level_sense,
    input  logic line_in,
    input  logic clr,
    output logic req
);

    line_state_t st_d, st_q;
    logic        rise;

    always_comb begin
        rise    = line_in & ~st_q.prev;
        st_d    = st_q;
        st_d.prev = line_in;
        if (level_sense) begin
            st_d.req = line_in;
        end else begin
            // a fresh edge overrides a clear arriving in the same cycle
            st_d.req = rise | (st_q.req & ~clr);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req = st_q.req;

endmodule

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
    parameter int                   NUM_LINES     = 8,
    parameter logic [NUM_LINES-1:0] WRITABLE_MASK = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 mode_wr,
    input  logic [NUM_LINES-1:0] mode_wdata,
    output logic [NUM_LINES-1:0] mode_rdata,
    input  logic [NUM_LINES-1:0] ack_clr,
    output logic [NUM_LINES-1:0] req_out
);

    logic [NUM_LINES-1:0] mode_cur;

    irq_trig_mode #(
        .NUM_LINES    (NUM_LINES),
        .WRITABLE_MASK(WRITABLE_MASK)
    ) u_mode (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (mode_wr),
        .wdata(mode_wdata),
        .mode (mode_cur)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        irq_line_cap u_cap (
            .clk        (clk),
            .rst_n      (rst_n),
            .level_sense(mode_cur[i]),
            .line_in    (irq_in[i]),
            .clr        (ack_clr[i]),
            .req        (req_out[i])
        );
    end

    assign mode_rdata = mode_cur;

endmodule

// File: rtl/irq_req_capture_chk.sv
module irq_req_capture_chk #(
    parameter int                   NUM_LINES     = 8,
    parameter logic [NUM_LINES-1:0] WRITABLE_MASK = '1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] irq_in,
    input logic                 mode_wr,
    input logic [NUM_LINES-1:0] mode_wdata,
    input logic [NUM_LINES-1:0] mode_rdata,
    input logic [NUM_LINES-1:0] ack_clr,
    input logic [NUM_LINES-1:0] req_out
);

    p_mode_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode_wr) |-> mode_rdata == ($past(mode_wdata) & WRITABLE_MASK));

    p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mode_wr) |-> $stable(mode_rdata));

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
        // R2 / R3 / R7: a level-sensed request mirrors the input one edge later
        p_level_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $past(mode_rdata[i]) |-> req_out[i] == $past(irq_in[i]));

        p_edge_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(mode_rdata[i]) && $past(irq_in[i]) && !$past(irq_in[i], 2))
            |-> req_out[i]);

        p_edge_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(mode_rdata[i]) && $past(req_out[i]) && !$past(ack_clr[i]))
            |-> req_out[i]);

        p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(mode_rdata[i]) && $past(ack_clr[i]) && !$past(irq_in[i]))
            |-> !req_out[i]);

        p_rise_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(mode_rdata[i]) && $past(ack_clr[i]) && $past(irq_in[i])
             && !$past(irq_in[i], 2)) |-> req_out[i]);
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            p_reset_r1: assert (req_out == '0 && mode_rdata == '0);
        end
    end

endmodule

bind irq_req_capture irq_req_capture_chk #(
    .NUM_LINES    (NUM_LINES),
    .WRITABLE_MASK(WRITABLE_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .mode_wr   (mode_wr),
    .mode_wdata(mode_wdata),
    .mode_rdata(mode_rdata),
    .ack_clr   (ack_clr),
    .req_out   (req_out)
);

// File: tb/tb_irq_req_capture.sv
module tb_irq_req_capture;

    localparam int       N    = 8;
    localparam logic [7:0] MASK = 8'hFB;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_in = '0;
    logic         mode_wr = 1'b0;
    logic [N-1:0] mode_wdata = '0;
    logic [N-1:0] mode_rdata;
    logic [N-1:0] ack_clr = '0;
    logic [N-1:0] req_out;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state
    bit m_req [N];
    bit m_prev[N];
    bit m_mode[N];

    always #10 clk = ~clk;   // 50 MHz

    irq_req_capture #(.NUM_LINES(N), .WRITABLE_MASK(MASK)) dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mode_wr(mode_wr),
        .mode_wdata(mode_wdata), .mode_rdata(mode_rdata),
        .ack_clr(ack_clr), .req_out(req_out)
    );

    function automatic logic [N-1:0] pack_bits(input bit a[N]);
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = a[i];
        return v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_req[i] = 0; m_prev[i] = 0; m_mode[i] = 0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                if (m_mode[i]) m_req[i] = irq_in[i];
                else if (irq_in[i] && !m_prev[i]) m_req[i] = 1;
                else if (ack_clr[i]) m_req[i] = 0;
                m_prev[i] = irq_in[i];
            end
            if (mode_wr)
                for (int i = 0; i < N; i++) m_mode[i] = mode_wdata[i] & MASK[i];
        end
    end

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("model req R2 R3 R4 R5 R6 R7 R8", req_out, pack_bits(m_req));
            check("model mode R9 R10", mode_rdata, pack_bits(m_mode));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        check("R1 reset req", req_out, '0);
        check("R1 reset mode", mode_rdata, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset req", req_out, '0);
        check("R1 after reset mode", mode_rdata, '0);

        // R9: masked write, bit 2 not writable
        mode_wr = 1; mode_wdata = 8'hFF;
        @(negedge clk);
        check("R9 masked write", mode_rdata, 8'hFB);
        mode_wr = 1; mode_wdata = 8'h01;   // line 0 level, others edge
        @(negedge clk);
        check("R9 second write", mode_rdata, 8'h01);
        mode_wr = 0; mode_wdata = 8'hAA;
        @(negedge clk);
        check("R10 no strobe", mode_rdata, 8'h01);

        // level line 0
        irq_in[0] = 1;
        @(negedge clk);
        check("R2 level set", req_out & 8'h01, 8'h01);
        ack_clr[0] = 1;
        @(negedge clk);
        check("R7 ack ignored on level", req_out & 8'h01, 8'h01);
        ack_clr[0] = 0; irq_in[0] = 0;
        @(negedge clk);
        check("R3 level clear", req_out & 8'h01, 8'h00);

        // edge line 2
        irq_in[2] = 1;
        @(negedge clk);
        check("R4 edge set", req_out & 8'h04, 8'h04);
        irq_in[2] = 0;
        @(negedge clk);
        check("R5 low keeps request", req_out & 8'h04, 8'h04);
        ack_clr[2] = 1;
        @(negedge clk);
        check("R6 ack clears edge", req_out & 8'h04, 8'h00);
        ack_clr[2] = 0; irq_in[2] = 1;
        @(negedge clk);
        ack_clr[2] = 1;
        @(negedge clk);
        ack_clr[2] = 0;
        @(negedge clk);
        check("R5 held high no reset", req_out & 8'h04, 8'h00);
        irq_in[2] = 0;
        @(negedge clk);

        // pending edge request, then clear and new rise together
        irq_in[3] = 1;
        @(negedge clk);
        irq_in[3] = 0;
        @(negedge clk);
        irq_in[3] = 1; ack_clr[3] = 1;
        @(negedge clk);
        check("R8 rise wins over ack", req_out & 8'h08, 8'h08);
        ack_clr[3] = 0; irq_in[3] = 0;
        @(negedge clk);

        // pseudo-random phase
        lfsr = 16'hACE1;
        for (int k = 0; k < 3000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            irq_in  = irq_in ^ (lfsr[7:0] & lfsr[15:8]);
            ack_clr = lfsr[11:4] & {8{lfsr[0]}};
            mode_wr = (lfsr[15:12] == 4'h5);
            mode_wdata = lfsr[9:2];
            @(negedge clk);
        end
        mode_wr = 0; ack_clr = '0;
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule